// File: doc/BRIEF.md
# Frequency-Jittered PWM Gate Timer

This block generates the switching rhythm for a current-mode flyback controller. On every switching period it raises the gate at the start of the period. It keeps the gate high through a hold window and then drops it. The gate drops either when a digital "current reached" flag arrives from the analog comparators or when the maximum duty limit is reached, whichever comes first. A static select input chooses between a low-frequency and a high-frequency nominal period.

The period is spread in time to lower the peak of each switching harmonic. A slow triangular offset is added to the nominal period count. That offset climbs by one count per step up to a positive bound, falls to the matching negative bound, and climbs again. A per-variant divider sets how many switching periods pass between steps, which keeps the sweep rate in the low hundreds of hertz for both variants.

The protection logic receives two outputs. The first is a one-clock strobe at each period start. The second is a level that marks the off part of an enabled period. Deasserting the enable input parks the block immediately. When enable returns, a fresh period starts.

Top module: `pwm_jitter_timer`

## Requirements
- R1: While rst_n is low, or after any clock edge at which enable is sampled low, gate, cycle_start and off_time are all 0.
- R2: At the first clock edge at which enable is sampled high after being low, cycle_start and gate both go to 1. cycle_start stays high for exactly one clock, and gate is 1 in every clock where cycle_start is 1.
- R3: The length of an uninterrupted period, measured in clocks between cycle_start pulses, is the nominal count plus the current offset. The nominal count is NOM_LO_CLKS when freq_sel is 0 and NOM_HI_CLKS when freq_sel is 1.
- R4: After reset the offset is 0. Each step changes it by +1 or -1. It rises to +DEV, falls to -DEV, then rises again, so the pattern repeats every 4·DEV steps. DEV is DEV_LO_CLKS or DEV_HI_CLKS as chosen by freq_sel.
- R5: One offset step is taken every DIV period starts, where DIV is TRI_DIV_LO or TRI_DIV_HI as chosen by freq_sel. The offset used for a period is the value held at that period's start, before the step.
- R6: When current_hit stays low, gate remains high for exactly floor(P·DUTY_PCT/100) clocks of a period of length P, then stays low until the next period.
- R7: Let HOLD = max(LEB_CLKS, MINON_CLKS). current_hit has no effect at any edge where fewer than HOLD clocks have passed since the period start. If current_hit is held high from the start, the gate is high for exactly HOLD+1 clocks.
- R8: If current_hit is sampled high at the edge that ends clock i of the period, with i ≥ HOLD, the gate is high for exactly i+1 clocks. After that the gate stays low for the rest of the period, even after current_hit returns low.
- R9: off_time is 1 exactly in the clocks of an enabled period where gate is 0.
- R10: Deasserting enable in the middle of a pulse, including during the hold window, drops gate at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; low forces the gate off and restarts the period |
| freq_sel | input | 1 | Static variant select: 0 low frequency, 1 high frequency |
| current_hit | input | 1 | Synchronous flag from the current/PWM comparators |
| gate | output | 1 | Power switch on request |
| cycle_start | output | 1 | One-clock strobe at each period start |
| off_time | output | 1 | High while the gate is off inside an enabled period |

## Verification
The assertions assume that freq_sel does not change while the block is running. They also assume that the parameters leave the duty limit above HOLD clocks, so that every pulse that ends on its own meets the minimum width. The period-spacing check covers only periods that run back to back with enable high. The stimulus sets freq_sel only while reset or disable is in force. It changes current_hit and enable only on falling clock edges, placing each edge at a chosen position inside the period so that the blanking boundary and the mid-pulse disable are both exercised.

// File: rtl/pwm_jit_pkg.sv
package pwm_jit_pkg;

    typedef enum logic {
        SWEEP_UP   = 1'b0,
        SWEEP_DOWN = 1'b1
    } sweep_dir_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/pwm_jit_tri.sv
module pwm_jit_tri
    import pwm_jit_pkg::*;
#(
    parameter int DEV_LO = 56,
    parameter int DEV_HI = 30,
    parameter int DIV_LO = 1,
    parameter int DIV_HI = 4,
    parameter int OW     = 8,
    parameter int DIVW   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 freq_sel,
    input  logic                 advance,
    output logic signed [OW-1:0] offset
);

    typedef struct packed {
        logic signed [OW-1:0] ofs;
        sweep_dir_e           dir;
        logic [DIVW-1:0]      div;
    } tri_state_t;

    localparam logic signed [OW-1:0] ONE = OW'(1);

    tri_state_t st_d, st_q;
    logic signed [OW-1:0] bound_pos, bound_neg;
    logic [DIVW-1:0]      div_last;

    always_comb begin
        bound_pos = freq_sel ? OW'(DEV_HI) : OW'(DEV_LO);
        bound_neg = -bound_pos;
        div_last  = freq_sel ? DIVW'(DIV_HI - 1) : DIVW'(DIV_LO - 1);
        st_d      = st_q;
        if (advance) begin
            if (st_q.div >= div_last) begin
                st_d.div = '0;
                if (st_q.dir == SWEEP_UP) begin
                    if (st_q.ofs >= bound_pos) begin
                        st_d.ofs = st_q.ofs - ONE;
                        st_d.dir = SWEEP_DOWN;
                    end else begin
                        st_d.ofs = st_q.ofs + ONE;
                        if (st_q.ofs + ONE >= bound_pos) st_d.dir = SWEEP_DOWN;
                    end
                end else begin
                    if (st_q.ofs <= bound_neg) begin
                        st_d.ofs = st_q.ofs + ONE;
                        st_d.dir = SWEEP_UP;
                    end else begin
                        st_d.ofs = st_q.ofs - ONE;
                        if (st_q.ofs - ONE <= bound_neg) st_d.dir = SWEEP_UP;
                    end
                end
            end else begin
                st_d.div = st_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ofs: '0, dir: SWEEP_UP, div: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign offset = st_q.ofs;

endmodule

// File: rtl/pwm_jit_period.sv
module pwm_jit_period #(
    parameter int NOM_LO   = 833,
    parameter int NOM_HI   = 435,
    parameter int DUTY_PCT = 80,
    parameter int CW       = 10,
    parameter int OW       = 8
) (
    input  logic                 freq_sel,
    input  logic signed [OW-1:0] offset_i,
    output logic [CW-1:0]        period_o,
    output logic [CW-1:0]        on_max_o
);

    localparam int PW = CW + 8;

    logic [CW-1:0]          nominal;
    logic signed [CW+1:0]   sum;
    logic [PW-1:0]          scaled;

    always_comb begin
        nominal  = freq_sel ? CW'(NOM_HI) : CW'(NOM_LO);
        sum      = $signed({2'b00, nominal}) + (CW+2)'(offset_i);
        period_o = sum[CW-1:0];
        scaled   = PW'(period_o) * PW'(DUTY_PCT);
        on_max_o = CW'(scaled / PW'(100));
    end

endmodule

// File: rtl/pwm_jit_core.sv
module pwm_jit_core #(
    parameter int CW   = 10,
    parameter int HOLD = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          current_hit,
    input  logic [CW-1:0] period_i,
    input  logic [CW-1:0] on_max_i,
    output logic          start_o,
    output logic          gate_o,
    output logic          cs_o,
    output logic          off_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] per;
        logic [CW-1:0] lim;
        logic          run;
        logic          gate;
        logic          cs;
        logic          off;
    } core_state_t;

    core_state_t st_d, st_q;
    logic period_end, hold_done, duty_end;

    always_comb begin
        period_end = (st_q.cnt == st_q.per - 1'b1);
        hold_done  = (st_q.cnt >= CW'(HOLD));
        duty_end   = ((st_q.cnt + 1'b1) >= st_q.lim);
        start_o    = enable && (!st_q.run || period_end);

        st_d    = st_q;
        st_d.cs = 1'b0;
        if (!enable) begin
            st_d.cnt  = '0;
            st_d.run  = 1'b0;
            st_d.gate = 1'b0;
            st_d.off  = 1'b0;
        end else if (start_o) begin
            st_d.cnt  = '0;
            st_d.per  = period_i;
            st_d.lim  = on_max_i;
            st_d.run  = 1'b1;
            st_d.gate = 1'b1;
            st_d.cs   = 1'b1;
            st_d.off  = 1'b0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.gate && (duty_end || (current_hit && hold_done))) begin
                st_d.gate = 1'b0;
            end
            st_d.off = !st_d.gate;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_o = st_q.gate;
    assign cs_o   = st_q.cs;
    assign off_o  = st_q.off;

endmodule

// File: rtl/pwm_jitter_timer.sv
module pwm_jitter_timer
    import pwm_jit_pkg::*;
#(
    parameter int NOM_LO_CLKS = 833,
    parameter int NOM_HI_CLKS = 435,
    parameter int DEV_LO_CLKS = 56,
    parameter int DEV_HI_CLKS = 30,
    parameter int TRI_DIV_LO  = 1,
    parameter int TRI_DIV_HI  = 4,
    parameter int LEB_CLKS    = 15,
    parameter int MINON_CLKS  = 20,
    parameter int DUTY_PCT    = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic freq_sel,
    input  logic current_hit,
    output logic gate,
    output logic cycle_start,
    output logic off_time
);

    localparam int NOM_MAX = imax(NOM_LO_CLKS, NOM_HI_CLKS);
    localparam int DEV_MAX = imax(DEV_LO_CLKS, DEV_HI_CLKS);
    localparam int DIV_MAX = imax(TRI_DIV_LO, TRI_DIV_HI);
    localparam int CW      = $clog2(NOM_MAX + DEV_MAX + 1);
    localparam int OW      = $clog2(DEV_MAX + 1) + 2;
    localparam int DIVW    = $clog2(DIV_MAX + 1) + 1;
    localparam int HOLD    = imax(LEB_CLKS, MINON_CLKS);

    logic signed [OW-1:0] offset;
    logic [CW-1:0]        period;
    logic [CW-1:0]        on_max;
    logic                 start;

    pwm_jit_tri #(
        .DEV_LO (DEV_LO_CLKS),
        .DEV_HI (DEV_HI_CLKS),
        .DIV_LO (TRI_DIV_LO),
        .DIV_HI (TRI_DIV_HI),
        .OW     (OW),
        .DIVW   (DIVW)
    ) u_tri (
        .clk      (clk),
        .rst_n    (rst_n),
        .freq_sel (freq_sel),
        .advance  (start),
        .offset   (offset)
    );

    pwm_jit_period #(
        .NOM_LO   (NOM_LO_CLKS),
        .NOM_HI   (NOM_HI_CLKS),
        .DUTY_PCT (DUTY_PCT),
        .CW       (CW),
        .OW       (OW)
    ) u_period (
        .freq_sel (freq_sel),
        .offset_i (offset),
        .period_o (period),
        .on_max_o (on_max)
    );

    pwm_jit_core #(
        .CW   (CW),
        .HOLD (HOLD)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .current_hit (current_hit),
        .period_i    (period),
        .on_max_i    (on_max),
        .start_o     (start),
        .gate_o      (gate),
        .cs_o        (cycle_start),
        .off_o       (off_time)
    );

endmodule

// File: rtl/pwm_jitter_timer_chk.sv
module pwm_jitter_timer_chk
    import pwm_jit_pkg::*;
#(
    parameter int NOM_LO_CLKS = 833,
    parameter int NOM_HI_CLKS = 435,
    parameter int DEV_LO_CLKS = 56,
    parameter int DEV_HI_CLKS = 30,
    parameter int LEB_CLKS    = 15,
    parameter int MINON_CLKS  = 20,
    parameter int DUTY_PCT    = 80
) (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic gate,
    input logic cycle_start,
    input logic off_time
);

    localparam int HOLD = imax(LEB_CLKS, MINON_CLKS);
    localparam int PMIN = imin(NOM_LO_CLKS - DEV_LO_CLKS, NOM_HI_CLKS - DEV_HI_CLKS);
    localparam int PMAX = imax(NOM_LO_CLKS + DEV_LO_CLKS, NOM_HI_CLKS + DEV_HI_CLKS);
    localparam int MAXW = (PMAX * DUTY_PCT) / 100;

    int unsigned high_run_q;
    int unsigned gap_q;
    logic        clean_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            high_run_q <= 0;
            gap_q      <= 0;
            clean_q    <= 1'b0;
        end else begin
            high_run_q <= gate ? high_run_q + 1 : 0;
            gap_q      <= cycle_start ? 1 : gap_q + 1;
            if (!enable)          clean_q <= 1'b0;
            else if (cycle_start) clean_q <= 1'b1;
        end
    end

    // R1
    disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!gate && !cycle_start && !off_time));

    // R2
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |-> gate);

    // R2
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |=> !cycle_start);

    // R9
    off_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        off_time |-> !gate);

    // R7
    min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate && high_run_q != 0 && $past(enable)) |-> (high_run_q >= HOLD + 1));

    // R6
    duty_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate |-> (high_run_q < MAXW));

    // R3
    period_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_start && clean_q) |-> (gap_q >= PMIN && gap_q <= PMAX));

endmodule

bind pwm_jitter_timer pwm_jitter_timer_chk #(
    .NOM_LO_CLKS (NOM_LO_CLKS),
    .NOM_HI_CLKS (NOM_HI_CLKS),
    .DEV_LO_CLKS (DEV_LO_CLKS),
    .DEV_HI_CLKS (DEV_HI_CLKS),
    .LEB_CLKS    (LEB_CLKS),
    .MINON_CLKS  (MINON_CLKS),
    .DUTY_PCT    (DUTY_PCT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .gate        (gate),
    .cycle_start (cycle_start),
    .off_time    (off_time)
);

// File: tb/tb_pwm_jitter_timer.sv
module tb_pwm_jitter_timer;

    localparam int NLO  = 100;
    localparam int NHI  = 50;
    localparam int DLO  = 4;
    localparam int DHI  = 2;
    localparam int VLO  = 1;
    localparam int VHI  = 2;
    localparam int LEB  = 15;
    localparam int MON  = 20;
    localparam int DUTY = 80;
    localparam int HOLD = (LEB > MON) ? LEB : MON;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic freq_sel = 1'b0;
    logic current_hit = 1'b0;
    logic gate, cycle_start, off_time;

    int checks = 0;
    int errors = 0;
    int starts = 0;
    int cyc = 0;

    pwm_jitter_timer #(
        .NOM_LO_CLKS (NLO), .NOM_HI_CLKS (NHI),
        .DEV_LO_CLKS (DLO), .DEV_HI_CLKS (DHI),
        .TRI_DIV_LO  (VLO), .TRI_DIV_HI  (VHI),
        .LEB_CLKS    (LEB), .MINON_CLKS  (MON),
        .DUTY_PCT    (DUTY)
    ) dut (
        .clk (clk), .rst_n (rst_n), .enable (enable), .freq_sel (freq_sel),
        .current_hit (current_hit), .gate (gate), .cycle_start (cycle_start),
        .off_time (off_time)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int tri_ofs(input int k, input bit sel);
        int dev = sel ? DHI : DLO;
        int div = sel ? VHI : VLO;
        int m   = (k / div) % (4 * dev);
        if (m <= dev) return m;
        if (m <= 3 * dev) return 2 * dev - m;
        return m - 4 * dev;
    endfunction

    function automatic int exp_period(input int k, input bit sel);
        return (sel ? NHI : NLO) + tri_ofs(k, sel);
    endfunction

    function automatic int duty_w(input int p);
        return (p * DUTY) / 100;
    endfunction

    task automatic do_reset(input bit sel);
        rst_n = 1'b0; enable = 1'b0; current_hit = 1'b0; freq_sel = sel;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        starts = 0;
        @(negedge clk);
    endtask

    task automatic wait_cs();
        for (int i = 0; i < 500; i++) begin
            if (cycle_start) return;
            @(negedge clk);
        end
        chk(1'b0, "R2 no start", 0, 1);
    endtask

    // Starts at a falling edge where cycle_start is seen; ends at the next one.
    // mode 0: no hit; 1: hit held from index a; 2: hit only at index a.
    task automatic measure(input int mode, input int a, output int width, output int period);
        bit fell = 1'b0;
        width = 0; period = 0;
        for (int i = 0; i < 2000; i++) begin
            if (i > 0 && cycle_start) begin
                period = i;
                break;
            end
            chk(off_time == !gate, "R9 off_time", off_time, !gate);
            if (gate) begin
                width++;
                if (fell) chk(1'b0, "R8 gate rose again", 1, 0);
            end else begin
                fell = 1'b1;
            end
            current_hit = (mode == 1) ? (i >= a) : (mode == 2) ? (i == a) : 1'b0;
            @(negedge clk);
        end
        current_hit = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; enable = 1'b1;
        repeat (3) @(negedge clk);
        chk(!gate && !cycle_start && !off_time, "R1 in reset", {gate, cycle_start, off_time}, 0);
        enable = 1'b0; rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(!gate && !cycle_start && !off_time, "R1 disabled", {gate, cycle_start, off_time}, 0);
    endtask

    task automatic t_start();
        do_reset(1'b0);
        enable = 1'b1;
        @(negedge clk);
        chk(cycle_start, "R2 start strobe", cycle_start, 1);
        chk(gate, "R2 gate at start", gate, 1);
        @(negedge clk);
        chk(!cycle_start, "R2 strobe one clock", cycle_start, 0);
    endtask

    task automatic t_sweep(input bit sel, input int n);
        int w, p;
        do_reset(sel);
        enable = 1'b1;
        @(negedge clk);
        wait_cs();
        for (int k = 0; k < n; k++) begin
            measure(0, 0, w, p);
            chk(p == exp_period(starts, sel), sel ? "R3 R5 hi period" : "R3 R4 lo period",
                p, exp_period(starts, sel));
            chk(w == duty_w(p), "R6 duty limit", w, duty_w(p));
            starts++;
        end
    endtask

    task automatic t_blank();
        int w, p;
        do_reset(1'b0);
        enable = 1'b1;
        @(negedge clk);
        wait_cs();
        measure(1, 0, w, p);
        chk(w == HOLD + 1, "R7 held hit", w, HOLD + 1);
        starts++;
        measure(2, HOLD - 1, w, p);
        chk(w == duty_w(p), "R7 pulse in window ignored", w, duty_w(p));
        starts++;
        measure(1, HOLD, w, p);
        chk(w == HOLD + 1, "R8 first honoured index", w, HOLD + 1);
        starts++;
        measure(2, 30, w, p);
        chk(w == 31, "R8 late hit", w, 31);
        chk(p == exp_period(starts, 1'b0), "R3 period with hit", p, exp_period(starts, 1'b0));
        starts++;
    endtask

    task automatic t_disable();
        int w, p;
        repeat (5) @(negedge clk);
        chk(gate, "R10 gate inside window", gate, 1);
        enable = 1'b0;
        @(negedge clk);
        chk(!gate, "R10 gate dropped", gate, 0);
        chk(!off_time && !cycle_start, "R1 quiet after disable", {off_time, cycle_start}, 0);
        starts++;
        for (int i = 0; i < 10; i++) begin
            if (gate || off_time || cycle_start) chk(1'b0, "R1 stays quiet", 1, 0);
            @(negedge clk);
        end
        enable = 1'b1;
        @(negedge clk);
        chk(cycle_start && gate, "R2 restart", {cycle_start, gate}, 3);
        measure(0, 0, w, p);
        chk(p == exp_period(starts, 1'b0), "R3 R4 period after restart", p, exp_period(starts, 1'b0));
        starts++;
    endtask

    initial begin
        t_reset();
        t_start();
        t_sweep(1'b0, 18);
        t_sweep(1'b1, 18);
        t_blank();
        t_disable();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule